// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether an instruction that traps on a comparison result must raise a trap. It takes two operands and a five-bit condition mask. Each mask bit enables one relation between the operands: signed less-than, signed greater-than, equality, unsigned less-than or unsigned greater-than. Any enabled relation that holds requests a trap. The enabled relations are ORed, so one mask can mix signed and unsigned tests.

A mode input selects one of two operand widths. In word mode only the low 32 bits of each operand take part, and bit 31 is the sign bit. In doubleword mode all 64 bits take part. The compare logic itself is combinational. The result goes through one register stage, so a trap request appears as a single-cycle pulse in the cycle after the valid strobe. With the pulse comes the trap sub-cause code that the program-exception logic downstream uses.

Top module: `trap_cond_unit`

## Requirements
- R1: While reset is asserted, and after reset until the first valid strobe, `trap_pulse` is 0 and `trap_cause` is 0.
- R2: Mask bit 4 (value 0x10) traps when operand A is less than operand B as signed numbers.
- R3: Mask bit 3 (value 0x08) traps when operand A is greater than operand B as signed numbers.
- R4: Mask bit 2 (value 0x04) traps when the operands are equal.
- R5: Mask bit 1 (value 0x02) traps when A is less than B as unsigned numbers. Mask bit 0 (value 0x01) traps when A is greater than B as unsigned numbers.
- R6: A trap is raised when at least one enabled relation holds. Relations whose mask bit is clear have no effect.
- R7: With `dword_mode` = 0, only bits 31:0 of each operand are compared, bit 31 is the sign bit, and bits 63:32 have no effect on the result.
- R8: With `dword_mode` = 1, all 64 bits are compared and bit 63 is the sign bit.
- R9: `trap_cause` is 4'h2 (program exception, trap sub-cause) in exactly the cycles where `trap_pulse` is 1, and 4'h0 in all other cycles.
- R10: A mask of 5'h00 never traps. A mask of 5'h1F always traps.
- R11: `trap_pulse` is registered. It rises in the cycle after a valid strobe whose compare hits, lasts one cycle for each strobe, and stays 0 in any cycle not preceded by a valid strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Strobe marking a compare request in this cycle |
| dword_mode | input | 1 | 1 selects a 64-bit compare, 0 selects a 32-bit compare of the low bits |
| cond_mask | input | 5 | Relation enables: bit 4 signed lt, bit 3 signed gt, bit 2 eq, bit 1 unsigned lt, bit 0 unsigned gt |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| trap_pulse | output | 1 | One-cycle trap request, one cycle after the strobe |
| trap_cause | output | 4 | Program-exception sub-cause that goes with the pulse |

## Verification
The assertions assume that `in_valid`, `dword_mode`, `cond_mask` and both operands hold known values in every cycle after reset. They also assume that these inputs change only between clock edges. Under those conditions, exactly one signed relation and exactly one unsigned relation are true on every cycle. The stimulus meets this by driving every input from reset onward and changing inputs only on the falling clock edge. It also returns the strobe and the mask to zero between requests, which gives the checks on idle cycles a defined starting point.

// File: rtl/trap_cmp_pkg.sv
`timescale 1ns/1ps
package trap_cmp_pkg;
  localparam int unsigned REL_N   = 5;
  localparam int unsigned CAUSE_W = 4;

  // relation vector bit positions; must match the mask bit decode
  localparam int unsigned REL_UGT = 0;
  localparam int unsigned REL_ULT = 1;
  localparam int unsigned REL_EQ  = 2;
  localparam int unsigned REL_SGT = 3;
  localparam int unsigned REL_SLT = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 4'h0,
    CAUSE_TRAP = 4'h2
  } trap_cause_e;
endpackage

// File: rtl/trap_opnd_prep.sv
`timescale 1ns/1ps
// Extends an operand to full width in signed and unsigned form for the selected mode
module trap_opnd_prep #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              dword_mode,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] sx_val,
  output logic [DATA_W-1:0] zx_val
);
  localparam int unsigned EXT_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] word_sx;
  logic [DATA_W-1:0] word_zx;

  generate
    if (EXT_W > 0) begin : g_ext
      assign word_sx = {{EXT_W{raw[WORD_W-1]}}, raw[WORD_W-1:0]};
      assign word_zx = {{EXT_W{1'b0}}, raw[WORD_W-1:0]};
    end else begin : g_noext
      assign word_sx = raw;
      assign word_zx = raw;
    end
  endgenerate

  always_comb begin
    if (dword_mode) begin
      sx_val = raw;
      zx_val = raw;
    end else begin
      sx_val = word_sx;
      zx_val = word_zx;
    end
  end
endmodule

// File: rtl/trap_rel_eval.sv
`timescale 1ns/1ps
// Evaluates the five compare relations on prepared operands
module trap_rel_eval
  import trap_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_sx,
  input  logic [DATA_W-1:0] b_sx,
  input  logic [DATA_W-1:0] a_zx,
  input  logic [DATA_W-1:0] b_zx,
  output logic [REL_N-1:0]  rel_vec
);
  logic s_lt, s_gt, u_lt, u_gt, same;

  always_comb begin
    s_lt = $signed(a_sx) < $signed(b_sx);
    s_gt = $signed(a_sx) > $signed(b_sx);
    u_lt = a_zx < b_zx;
    u_gt = a_zx > b_zx;
    same = a_zx == b_zx;
    rel_vec          = '0;
    rel_vec[REL_SLT] = s_lt;
    rel_vec[REL_SGT] = s_gt;
    rel_vec[REL_EQ]  = same;
    rel_vec[REL_ULT] = u_lt;
    rel_vec[REL_UGT] = u_gt;
  end
endmodule

// File: rtl/trap_cond_unit.sv
`timescale 1ns/1ps
module trap_cond_unit
  import trap_cmp_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               dword_mode,
  input  logic [REL_N-1:0]   cond_mask,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  output logic               trap_pulse,
  output logic [CAUSE_W-1:0] trap_cause
);
  localparam logic [REL_N-1:0] MASK_ALL = {REL_N{1'b1}};

  // reset: asserted asynchronously, released through a short flop chain
  logic [SYNC_LEN-1:0] rst_chain;
  logic                rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain <= '0;
    else        rst_chain <= {rst_chain[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rst_chain[SYNC_LEN-1];

  // operand preparation
  logic [DATA_W-1:0] a_sx, a_zx, b_sx, b_zx;

  trap_opnd_prep #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_prep_a (
    .dword_mode (dword_mode),
    .raw        (opnd_a),
    .sx_val     (a_sx),
    .zx_val     (a_zx)
  );

  trap_opnd_prep #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_prep_b (
    .dword_mode (dword_mode),
    .raw        (opnd_b),
    .sx_val     (b_sx),
    .zx_val     (b_zx)
  );

  logic [REL_N-1:0] rel_vec;

  trap_rel_eval #(.DATA_W(DATA_W)) u_rel (
    .a_sx    (a_sx),
    .b_sx    (b_sx),
    .a_zx    (a_zx),
    .b_zx    (b_zx),
    .rel_vec (rel_vec)
  );

  // next state
  logic               hit;
  logic               trap_d, trap_q;
  logic [CAUSE_W-1:0] cause_d, cause_q;

  always_comb begin
    hit     = |(cond_mask & rel_vec);
    trap_d  = in_valid & hit;
    cause_d = trap_d ? CAUSE_TRAP : CAUSE_NONE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      trap_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      trap_q  <= trap_d;
      cause_q <= cause_d;
    end
  end

  assign trap_pulse = trap_q;
  assign trap_cause = cause_q;

  // R2 R3 R4: exactly one signed relation holds
  signed_rel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones({rel_vec[REL_SLT], rel_vec[REL_SGT], rel_vec[REL_EQ]}) == 1);

  // R5: exactly one unsigned relation holds
  unsigned_rel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones({rel_vec[REL_ULT], rel_vec[REL_UGT], rel_vec[REL_EQ]}) == 1);

  // R10
  zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && cond_mask == '0) |=> !trap_pulse);

  // R10
  full_mask_fires_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && cond_mask == MASK_ALL) |=> trap_pulse);

  // R11
  no_strobe_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !trap_pulse);

  // R7
  word_equal_fires_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !dword_mode && cond_mask[REL_EQ] &&
     opnd_a[WORD_W-1:0] == opnd_b[WORD_W-1:0]) |=> trap_pulse);

  // R9
  cause_tracks_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    trap_pulse ? (trap_cause == CAUSE_TRAP) : (trap_cause == CAUSE_NONE));
endmodule

// File: tb/trap_cond_unit_tb.sv
`timescale 1ns/1ps
module trap_cond_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        dword_mode;
  logic [4:0]  cond_mask;
  logic [63:0] opnd_a, opnd_b;
  logic        trap_pulse;
  logic [3:0]  trap_cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  trap_cond_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .dword_mode (dword_mode),
    .cond_mask  (cond_mask),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .trap_pulse (trap_pulse),
    .trap_cause (trap_cause)
  );

  // expected trap decision built from the requirement text
  function automatic bit model(input logic [4:0] m, input logic [63:0] a,
                               input logic [63:0] b, input bit dw);
    longint signed   sa, sb;
    longint unsigned ua, ub;
    if (dw) begin
      sa = a; sb = b; ua = a; ub = b;
    end else begin
      sa = longint'($signed(a[31:0]));
      sb = longint'($signed(b[31:0]));
      ua = {32'h0, a[31:0]};
      ub = {32'h0, b[31:0]};
    end
    return (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
           (m[1] && ua < ub) || (m[0] && ua > ub);
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // drive one request, then check the registered result one edge later
  task automatic run_one(input string req, input logic [4:0] m, input logic [63:0] a,
                         input logic [63:0] b, input bit dw);
    bit exp;
    exp = model(m, a, b, dw);
    @(negedge clk);
    in_valid = 1'b1; cond_mask = m; opnd_a = a; opnd_b = b; dword_mode = dw;
    @(negedge clk);
    in_valid = 1'b0; cond_mask = '0;
    check(req, {63'h0, trap_pulse}, {63'h0, exp});
    check({req, " cause"}, {60'h0, trap_cause}, exp ? 64'h2 : 64'h0);
    @(negedge clk);
    check({req, " one-cycle"}, {63'h0, trap_pulse}, 64'h0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; cond_mask = '0; dword_mode = 1'b1;
    opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset pulse", {63'h0, trap_pulse}, 64'h0);
    check("R1 in reset cause", {60'h0, trap_cause}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset pulse", {63'h0, trap_pulse}, 64'h0);
    check("R1 after reset cause", {60'h0, trap_cause}, 64'h0);
  endtask

  task automatic t_signed;
    run_one("R2 slt hit", 5'h10, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 1'b1);
    run_one("R2 slt miss", 5'h10, 64'h5, 64'h5, 1'b1);
    run_one("R3 sgt hit", 5'h08, 64'h1, 64'h8000_0000_0000_0000, 1'b1);
    run_one("R3 sgt miss", 5'h08, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1);
  endtask

  task automatic t_equal;
    run_one("R4 eq hit", 5'h04, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1'b1);
    run_one("R4 eq miss", 5'h04, 64'h1, 64'h2, 1'b1);
  endtask

  task automatic t_unsigned;
    run_one("R5 ult hit", 5'h02, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    run_one("R5 ult miss", 5'h02, 64'h8000_0000_0000_0000, 64'h1, 1'b1);
    run_one("R5 ugt hit", 5'h01, 64'h8000_0000_0000_0000, 64'h1, 1'b1);
    run_one("R5 ugt miss", 5'h01, 64'h3, 64'h3, 1'b1);
  endtask

  task automatic t_combine;
    run_one("R6 mixed any", 5'h11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1);
    run_one("R6 disabled rel", 5'h0A, 64'h2, 64'h7, 1'b1);
    run_one("R6 ult plus sgt", 5'h0A, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7, 1'b1);
  endtask

  task automatic t_word;
    run_one("R7 upper ignored eq", 5'h04, 64'hAAAA_0000_0000_0042, 64'h5555_0000_0000_0042, 1'b0);
    run_one("R7 sign bit31", 5'h10, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 1'b0);
    run_one("R7 unsigned low", 5'h01, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 1'b0);
    run_one("R7 upper ignored lt", 5'h12, 64'hFFFF_FFFF_0000_0003, 64'h0000_0000_0000_0003, 1'b0);
  endtask

  task automatic t_dword;
    run_one("R8 upper counts eq", 5'h04, 64'hAAAA_0000_0000_0042, 64'h5555_0000_0000_0042, 1'b1);
    run_one("R8 sign bit63", 5'h10, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 1'b1);
    run_one("R8 upper ult", 5'h02, 64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0000, 1'b1);
  endtask

  task automatic t_masks;
    run_one("R10 zero mask", 5'h00, 64'h1, 64'h2, 1'b1);
    run_one("R10 full mask eq", 5'h1F, 64'h9, 64'h9, 1'b0);
    run_one("R10 full mask lt", 5'h1F, 64'h0, 64'h9, 1'b1);
  endtask

  task automatic t_strobe;
    @(negedge clk);
    in_valid = 1'b0; cond_mask = 5'h1F; opnd_a = 64'h1; opnd_b = 64'h1;
    @(negedge clk);
    check("R11 no strobe", {63'h0, trap_pulse}, 64'h0);
    check("R9 idle cause", {60'h0, trap_cause}, 64'h0);
    in_valid = 1'b1;
    @(negedge clk);
    check("R11 back to back first", {63'h0, trap_pulse}, 64'h1);
    cond_mask = 5'h00;
    @(negedge clk);
    check("R11 back to back second", {63'h0, trap_pulse}, 64'h0);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_signed();
    t_equal();
    t_unsigned();
    t_combine();
    t_word();
    t_dword();
    t_masks();
    t_strobe();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule